// File: doc/BRIEF.md
# Powerdown and Calibration Sequencer

This block controls power-up and calibration for a clock-recovery receiver. A single active-high control pin does two jobs. While the pin is high, the receiver is powered down: the serial outputs are disabled, the core is held in reset and the loss-of-lock alarm is masked. When the pin falls after a long enough high period, a new bring-up sequence starts. The core first leaves powerdown while still held in reset. It then waits for a valid reference clock and raises a calibration request, which it holds until calibration completes. Finally it runs an acquisition timer before it reports that the loop is ready.

The raw pin passes through a synchronizer inside the block. The reference-valid flag and the calibration-done flag are already in the system clock domain. All timing limits are counted in system-clock cycles, so the same block serves any clock rate. A reset is treated as a qualified power-on. A pin that is tied low or left floating therefore still starts the receiver once after reset.

Top module: `pdcal_seq`

## Requirements
- R1: Whenever the synchronized control level is high, from any state, out_en goes to 0 and core_rst to 1. Both take effect on the clock edge after the synchronized level is seen.
- R2: lol_mask is 1 while powered down and while calibration is requested. It is 0 while waiting for the reference, while acquiring and while running.
- R3: The control pin passes through a two-flop synchronizer. A change on the raw pin reaches the outputs on the third rising clock edge after it, and not before.
- R4: A falling edge leaves powerdown only if the synchronized pin was high for at least MIN_HIGH_CYCLES consecutive cycles. A shorter pulse leaves the block powered down (out_en=0, core_rst=1) until a qualified pulse arrives.
- R5: After a qualified release, if ref_ok is 0, the block holds out_en=1, core_rst=1, cal_req=0 and lol_mask=0 until ref_ok becomes 1.
- R6: With ref_ok=1, the block deasserts core_rst and holds cal_req=1 until cal_done=1. If ref_ok drops while cal_req is high, the block returns to waiting for the reference. cal_done has no effect outside the calibration request.
- R7: acq_done rises exactly ACQ_CYCLES+1 clock edges after cal_req rose, provided cal_done arrives in time. If cal_done arrives later, acq_done rises on the second edge after cal_done is applied.
- R8: While rst is high, the outputs are out_en=0, core_rst=1, cal_req=0, lol_mask=1, acq_done=0. After rst is released with the pin low, the block starts the bring-up sequence without needing a pulse.
- R9: A rising pin while running clears acq_done and enters powerdown. A later qualified release restarts the whole sequence, including a fresh acquisition timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pdcal_pin | input | 1 | Raw powerdown/calibrate control pin, asynchronous |
| ref_ok | input | 1 | Reference clock present and valid |
| cal_done | input | 1 | Calibration engine has finished |
| out_en | output | 1 | Enable for the recovered data and clock drivers |
| core_rst | output | 1 | Reset to the recovery core |
| cal_req | output | 1 | Calibration request, held until cal_done |
| lol_mask | output | 1 | Forces the loss-of-lock alarm inactive |
| acq_done | output | 1 | Acquisition time has elapsed; loop may report lock |

## Verification
The bench builds the block with MIN_HIGH_CYCLES=8 and ACQ_CYCLES=40, and keeps the two-stage synchronizer. The short high-time limit lets 7-cycle and 8-cycle pulses land on either side of the qualification boundary. The short acquisition window lets the bench check the exact edge on which acq_done rises, both when cal_done arrives early and when it arrives after the timer has expired. With these values, a loss of the reference during calibration and re-entry from the running state also fit within a short run.

// File: rtl/pdcal_pkg.sv
package pdcal_pkg;

  typedef enum logic [2:0] {
    ST_POWERDOWN = 3'd0,
    ST_WAIT_REF  = 3'd1,
    ST_CALIBRATE = 3'd2,
    ST_ACQUIRE   = 3'd3,
    ST_RUN       = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic out_en;
    logic core_rst;
    logic cal_req;
    logic lol_mask;
    logic acq_done;
  } seq_outs_t;

  function automatic seq_outs_t decode_outs(input seq_state_e st);
    seq_outs_t o;
    o = '{out_en: 1'b0, core_rst: 1'b1, cal_req: 1'b0, lol_mask: 1'b1, acq_done: 1'b0};
    case (st)
      ST_POWERDOWN: o = '{out_en: 1'b0, core_rst: 1'b1, cal_req: 1'b0, lol_mask: 1'b1, acq_done: 1'b0};
      ST_WAIT_REF:  o = '{out_en: 1'b1, core_rst: 1'b1, cal_req: 1'b0, lol_mask: 1'b0, acq_done: 1'b0};
      ST_CALIBRATE: o = '{out_en: 1'b1, core_rst: 1'b0, cal_req: 1'b1, lol_mask: 1'b1, acq_done: 1'b0};
      ST_ACQUIRE:   o = '{out_en: 1'b1, core_rst: 1'b0, cal_req: 1'b0, lol_mask: 1'b0, acq_done: 1'b0};
      ST_RUN:       o = '{out_en: 1'b1, core_rst: 1'b0, cal_req: 1'b0, lol_mask: 1'b0, acq_done: 1'b1};
      default:      o = '{out_en: 1'b0, core_rst: 1'b1, cal_req: 1'b0, lol_mask: 1'b1, acq_done: 1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pdcal_sync.sv
module pdcal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic pin_lvl
);

  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= pin_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign pin_lvl = chain[NS-1];

endmodule

// File: rtl/pdcal_high_qual.sv
module pdcal_high_qual #(
  parameter int MIN_HIGH_CYCLES = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_lvl,
  output logic qualified
);

  localparam int MH = (MIN_HIGH_CYCLES < 1) ? 1 : MIN_HIGH_CYCLES;
  localparam int CW = $clog2(MH + 1) + 1;
  localparam logic [CW-1:0] LIMIT  = CW'(MH);
  localparam logic [CW-1:0] LIM_M1 = CW'(MH - 1);

  logic [CW-1:0] hi_cnt;
  logic          pin_prev;
  logic          rise;

  assign rise = pin_lvl && !pin_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      pin_prev  <= 1'b0;
      qualified <= 1'b1;
    end else begin
      pin_prev <= pin_lvl;
      if (rise) begin
        hi_cnt    <= CW'(1);
        qualified <= (MH <= 1);
      end else if (pin_lvl) begin
        if (hi_cnt < LIMIT) hi_cnt <= hi_cnt + 1'b1;
        if (hi_cnt >= LIM_M1) qualified <= 1'b1;
      end else begin
        hi_cnt <= '0;
      end
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= LIMIT);

  p_rise_clears_r4: assert property (@(posedge clk) disable iff (rst)
    ((MH > 1) && pin_lvl && !pin_prev) |=> !qualified);

endmodule

// File: rtl/pdcal_acq_timer.sv
module pdcal_acq_timer #(
  parameter int ACQ_CYCLES = 375000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  localparam int AC = (ACQ_CYCLES < 1) ? 1 : ACQ_CYCLES;
  localparam int CW = $clog2(AC + 1) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(AC);

  logic [CW-1:0] cnt;

  assign expired = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  p_expired_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (expired && run) |=> expired);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

endmodule

// File: rtl/pdcal_fsm.sv
module pdcal_fsm
  import pdcal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin_lvl,
  input  logic qualified,
  input  logic ref_ok,
  input  logic cal_done,
  input  logic acq_expired,
  output logic timer_run,
  output logic out_en,
  output logic core_rst,
  output logic cal_req,
  output logic lol_mask,
  output logic acq_done
);

  seq_state_e st, st_nx;
  seq_outs_t  outs_q, outs_nx;

  always_comb begin
    st_nx = st;
    if (pin_lvl) begin
      st_nx = ST_POWERDOWN;
    end else begin
      case (st)
        ST_POWERDOWN: if (qualified) st_nx = ST_WAIT_REF;
        ST_WAIT_REF:  if (ref_ok) st_nx = ST_CALIBRATE;
        ST_CALIBRATE: begin
          if (!ref_ok)       st_nx = ST_WAIT_REF;
          else if (cal_done) st_nx = ST_ACQUIRE;
        end
        ST_ACQUIRE:   if (acq_expired) st_nx = ST_RUN;
        ST_RUN:       st_nx = ST_RUN;
        default:      st_nx = ST_POWERDOWN;
      endcase
    end
  end

  assign outs_nx = decode_outs(st_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_POWERDOWN;
      outs_q <= decode_outs(ST_POWERDOWN);
    end else begin
      st     <= st_nx;
      outs_q <= outs_nx;
    end
  end

  assign timer_run = (st == ST_CALIBRATE) || (st == ST_ACQUIRE);
  assign out_en    = outs_q.out_en;
  assign core_rst  = outs_q.core_rst;
  assign cal_req   = outs_q.cal_req;
  assign lol_mask  = outs_q.lol_mask;
  assign acq_done  = outs_q.acq_done;

  p_pd_forces_off_r1: assert property (@(posedge clk) disable iff (rst)
    pin_lvl |=> (!out_en && core_rst && !acq_done));

  p_mask_in_pd_r2: assert property (@(posedge clk) disable iff (rst)
    pin_lvl |=> lol_mask);

  p_leave_pd_qualified_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en) |-> ($past(qualified) && !$past(pin_lvl)));

  p_req_needs_ref_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_req) |-> $past(ref_ok));

  p_req_out_of_reset_r6: assert property (@(posedge clk) disable iff (rst)
    cal_req |-> (!core_rst && out_en));

  p_run_needs_timer_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(acq_done) |-> $past(acq_expired));

endmodule

// File: rtl/pdcal_seq.sv
module pdcal_seq #(
  parameter int SYNC_STAGES     = 2,
  parameter int MIN_HIGH_CYCLES = 250,
  parameter int ACQ_CYCLES      = 375000
) (
  input  logic clk,
  input  logic rst,
  input  logic pdcal_pin,
  input  logic ref_ok,
  input  logic cal_done,
  output logic out_en,
  output logic core_rst,
  output logic cal_req,
  output logic lol_mask,
  output logic acq_done
);

  logic pin_lvl;
  logic qualified;
  logic timer_run;
  logic acq_expired;

  pdcal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_raw (pdcal_pin),
    .pin_lvl (pin_lvl)
  );

  pdcal_high_qual #(.MIN_HIGH_CYCLES(MIN_HIGH_CYCLES)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .pin_lvl   (pin_lvl),
    .qualified (qualified)
  );

  pdcal_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (timer_run),
    .expired (acq_expired)
  );

  pdcal_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pin_lvl     (pin_lvl),
    .qualified   (qualified),
    .ref_ok      (ref_ok),
    .cal_done    (cal_done),
    .acq_expired (acq_expired),
    .timer_run   (timer_run),
    .out_en      (out_en),
    .core_rst    (core_rst),
    .cal_req     (cal_req),
    .lol_mask    (lol_mask),
    .acq_done    (acq_done)
  );

endmodule

// File: tb/pdcal_seq_tb.sv
module pdcal_seq_tb;

  localparam int MIN_HI = 8;
  localparam int ACQ    = 40;
  localparam int WD     = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic ref_ok = 1'b0;
  logic cal_done = 1'b0;
  logic out_en, core_rst, cal_req, lol_mask, acq_done;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pdcal_seq #(
    .SYNC_STAGES(2),
    .MIN_HIGH_CYCLES(MIN_HI),
    .ACQ_CYCLES(ACQ)
  ) u_dut (
    .clk(clk), .rst(rst), .pdcal_pin(pin), .ref_ok(ref_ok), .cal_done(cal_done),
    .out_en(out_en), .core_rst(core_rst), .cal_req(cal_req),
    .lol_mask(lol_mask), .acq_done(acq_done)
  );

  // Output vector order: {out_en, core_rst, cal_req, lol_mask, acq_done}
  localparam logic [4:0] PD   = 5'b01010;
  localparam logic [4:0] WREF = 5'b11000;
  localparam logic [4:0] CAL  = 5'b10110;
  localparam logic [4:0] ACQS = 5'b10000;
  localparam logic [4:0] RUN  = 5'b10001;

  // Vector fields: [15] pin, [14] ref_ok, [13] cal_done, [12:5] wait cycles, [4:0] expected
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'd5,  WREF},  // R8 start after reset, R5 waiting for ref
    {1'b0, 1'b1, 1'b0, 8'd5,  CAL },  // R6 request held, R2 mask during request
    {1'b0, 1'b1, 1'b1, 8'd50, RUN },  // R7 acquisition then run
    {1'b1, 1'b1, 1'b0, 8'd12, PD  },  // R9 R1 R2 powerdown from run
    {1'b0, 1'b1, 1'b0, 8'd5,  CAL },  // R4 qualified release, R9 restart
    {1'b1, 1'b1, 1'b0, 8'd4,  PD  },  // R1 powerdown during calibration
    {1'b0, 1'b1, 1'b0, 8'd10, PD  },  // R4 short pulse ignored
    {1'b1, 1'b0, 1'b0, 8'd8,  PD  },  // R1 exactly minimum high time
    {1'b0, 1'b0, 1'b0, 8'd6,  WREF},  // R4 boundary qualifies, R5
    {1'b0, 1'b1, 1'b0, 8'd3,  CAL },  // R6
    {1'b0, 1'b0, 1'b0, 8'd3,  WREF},  // R6 reference lost during request
    {1'b0, 1'b1, 1'b1, 8'd60, RUN }   // R7
  };

  function automatic logic [4:0] outs();
    return {out_en, core_rst, cal_req, lol_mask, acq_done};
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check1(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (WD) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements): got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    step(5);
    check("R8 outputs during reset", outs(), PD);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      pin      = VEC[v][15];
      ref_ok   = VEC[v][14];
      cal_done = VEC[v][13];
      step(int'(VEC[v][12:5]));
      check($sformatf("table vector %0d", v), outs(), VEC[v][4:0]);
    end

    // R3: synchronizer latency from run
    pin = 1'b1;
    step(2);
    check1("R3 no change after two edges", out_en, 1'b1);
    step(1);
    check1("R3 R1 disabled on third edge", out_en, 1'b0);
    step(10);

    // R5 R6: cal_done ignored while waiting for ref
    ref_ok = 1'b0; cal_done = 1'b1; pin = 1'b0;
    step(5);
    check("R6 cal_done ignored while waiting, R5", outs(), WREF);
    ref_ok = 1'b1;
    step(1);
    check1("R6 request rises", cal_req, 1'b1);
    step(ACQ);
    check1("R7 not done at ACQ edges", acq_done, 1'b0);
    step(1);
    check1("R7 done at ACQ+1 edges", acq_done, 1'b1);

    // R7: late cal_done
    pin = 1'b1; cal_done = 1'b0;
    step(10);
    pin = 1'b0;
    step(ACQ + 10);
    check("R7 R6 request held without cal_done", outs(), CAL);
    cal_done = 1'b1;
    step(1);
    check("R7 acquire after late cal_done", outs(), ACQS);
    step(1);
    check("R7 run one edge later", outs(), RUN);

    // R4: 7-cycle pulse fails, 8-cycle pulse qualifies
    cal_done = 1'b0;
    pin = 1'b1;
    step(MIN_HI - 1);
    pin = 1'b0;
    step(6);
    check("R4 pulse one short stays down", outs(), PD);
    pin = 1'b1;
    step(MIN_HI);
    pin = 1'b0;
    step(6);
    check("R4 minimum pulse releases", outs(), CAL);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule